// File: doc/BRIEF.md
# Transition-Count Noise Shaper for Unit-Element DACs

This block belongs to a dynamic-element-matching path in front of a unit-element DAC. For each quantizer sample it decides how many elements should switch state, counting up and down transitions together. The decision is made so that this count does not follow the signal, and so that its deviation from a programmed mean has a high-pass spectrum. Element selection takes the result downstream: the total count, the number of elements that must turn on, and a flag that says whether that split can be realised given how many elements were on and off.

The count must have the same parity as the level change, because up transitions minus down transitions equals that change. When the parity of the change matches the parity of the programmed mean, the mean is used unchanged. Otherwise a small noise-shaping loop picks +1 or −1. A first-order loop is always present. A second-order loop, with a feed-forward term that keeps it stable, can be selected at run time. A linear-feedback shift register supplies a dither bit that settles a tie when the loop's decision quantity is exactly zero.

Samples arrive on a valid/ready stream and results leave on another. The single output register accepts a new sample when it is empty or is being drained in the same cycle. While the output is stalled, the result holds and the input is back-pressured. Loop state, dither and results advance only on an accepted sample.

Top module: `xcount_shaper`

## Requirements
- R1: Every result's total count `out_total` has the same least significant bit as the accepted sample's level change `cur_level - prev_level`.
- R2: When bit 0 of the level change equals bit 0 of `avg_count`, `out_total` equals `avg_count` and no loop state changes.
- R3: When those bits differ, `out_total` is `avg_count + y` with y = +1 if the loop quantity is negative and y = −1 if it is positive. In first-order mode the loop quantity is integrator 1, which then adds y.
- R4: When the loop quantity is exactly zero, y = +1 if dither bit 0 is 1 and −1 otherwise. The dither register is 16 bits, resets to 0xACE1 and shifts left on every accepted sample, inserting the XOR of bits 15, 13, 12 and 10. After reset the first odd-parity sample therefore gives `avg_count + 1`.
- R5: `out_up` equals `(out_total + cur_level - prev_level) / 2`.
- R6: `out_ok` is 1 exactly when all of the following hold: `out_total >= 0`; `out_up >= 0`; `out_up <= N_ELEM - prev_level`; `cur_level - out_up` lies between 0 and `prev_level`.
- R7: With `order2` = 1, the loop quantity is integrator 2 plus twice integrator 1. On an odd-parity sample, integrator 1 adds y and integrator 2 then adds the new integrator 1. Both integrators are 6-bit signed registers that saturate at −32 and +31.
- R8: `in_ready` = !`out_valid` || `out_ready`. An accepted sample appears on the outputs at the next clock edge with `out_valid` = 1. An undrained result holds its value. A drained result with no new sample clears `out_valid`.
- R9: A synchronous reset clears `out_valid` and both integrators and loads the dither seed, so `in_ready` is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| order2 | input | 1 | 1 selects second-order shaping |
| avg_count | input | LEVEL_W | Programmed mean transition count |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample accepted this cycle when high with in_valid |
| cur_level | input | LEVEL_W | Current number of elements on (0..N_ELEM) |
| prev_level | input | LEVEL_W | Previous number of elements on (0..N_ELEM) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_total | output | CNT_W | Signed total transitions (up plus down) |
| out_up | output | CNT_W | Signed number of elements to turn on |
| out_ok | output | 1 | Split is realisable with the available elements |

## Verification
A corrupted integrator or dither register does not show up at once. It first shows in the sign of the next odd-parity result, which reaches `out_total` one clock after that sample is accepted. From then on the ±1 sequence drifts away from the reference, which tracks the integrators, dither and output register independently. A wrong parity or split shows up in the same result as a broken link between `out_total`, `out_up` and the inputs. Stall handling errors show up in the cycle when `out_valid` or a held value moves while `out_ready` is low.

// File: rtl/xts_pkg.sv
package xts_pkg;
  // Loop offset encoding carried between the loop and the count splitter
  typedef enum logic [1:0] {
    OFS_ZERO = 2'b00,
    OFS_PLUS = 2'b01,
    OFS_MINUS = 2'b11
  } ofs_t;

  function automatic int ofs_value(input ofs_t o);
    case (o)
      OFS_PLUS:  return 1;
      OFS_MINUS: return -1;
      default:   return 0;
    endcase
  endfunction
endpackage

// File: rtl/xts_dither_lfsr.sv
module xts_dither_lfsr #(
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic dith
);
  logic [LFSR_W-1:0] state;
  logic feed;

  assign feed = ^(state & TAPS);
  assign dith = state[0];

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else if (step) state <= {state[LFSR_W-2:0], feed};
  end
endmodule

// File: rtl/xts_shaping_loop.sv
module xts_shaping_loop
  import xts_pkg::*;
#(
  parameter int INT_W = 6,
  parameter bit HAS_ORDER2 = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic odd,
  input  logic order2,
  input  logic dith,
  output ofs_t decision
);
  localparam int QW = INT_W + 3;
  localparam int MAXV = (1 << (INT_W - 1)) - 1;
  localparam int MINV = -(1 << (INT_W - 1));

  logic signed [INT_W-1:0] s1_q;
  logic signed [INT_W-1:0] s1_d;
  logic signed [INT_W-1:0] s2_q;
  logic signed [QW-1:0] quant;
  logic pick_plus;

  function automatic logic signed [INT_W-1:0] sat_add(
      input logic signed [INT_W-1:0] a, input logic signed [QW-1:0] b);
    logic signed [QW-1:0] s;
    s = QW'(a) + b;
    if (s > QW'(MAXV)) return INT_W'(MAXV);
    if (s < QW'(MINV)) return INT_W'(MINV);
    return s[INT_W-1:0];
  endfunction

  generate
    if (HAS_ORDER2) begin : g_two
      logic use2;
      assign use2 = order2;
      always_comb begin
        if (use2) quant = QW'(s2_q) + (QW'(s1_q) <<< 1);
        else      quant = QW'(s1_q);
      end
      always_ff @(posedge clk) begin
        if (rst) s2_q <= '0;
        else if (step && odd && use2) s2_q <= sat_add(s2_q, QW'(s1_d));
      end
    end else begin : g_one
      assign quant = QW'(s1_q);
      always_ff @(posedge clk) begin
        if (rst) s2_q <= '0;
      end
    end
  endgenerate

  assign pick_plus = (quant < 0) || ((quant == 0) && dith);
  assign decision = pick_plus ? OFS_PLUS : OFS_MINUS;
  assign s1_d = sat_add(s1_q, pick_plus ? QW'(1) : -QW'(1));

  always_ff @(posedge clk) begin
    if (rst) s1_q <= '0;
    else if (step && odd) s1_q <= s1_d;
  end
endmodule

// File: rtl/xts_count_split.sv
module xts_count_split
  import xts_pkg::*;
#(
  parameter int N_ELEM = 16,
  parameter int LEVEL_W = 5,
  parameter int CNT_W = 7
) (
  input  logic [LEVEL_W-1:0] cur_level,
  input  logic [LEVEL_W-1:0] prev_level,
  input  logic [LEVEL_W-1:0] avg_count,
  input  ofs_t loop_ofs,
  output logic odd,
  output logic signed [CNT_W-1:0] total,
  output logic signed [CNT_W-1:0] up,
  output logic ok
);
  logic signed [CNT_W-1:0] cur_s, prev_s, avg_s, diff, keep, off_cnt, sum;

  assign cur_s  = $signed({2'b00, cur_level});
  assign prev_s = $signed({2'b00, prev_level});
  assign avg_s  = $signed({2'b00, avg_count});
  assign diff   = cur_s - prev_s;
  assign odd    = diff[0] ^ avg_count[0];

  always_comb begin
    total = avg_s;
    if (odd) begin
      if (loop_ofs == OFS_PLUS) total = avg_s + CNT_W'(1);
      else if (loop_ofs == OFS_MINUS) total = avg_s - CNT_W'(1);
    end
  end

  assign sum     = total + diff;
  assign up      = sum >>> 1;
  assign keep    = cur_s - up;
  assign off_cnt = CNT_W'(N_ELEM) - prev_s;
  assign ok = (total >= 0) && (up >= 0) && (up <= off_cnt) &&
              (keep >= 0) && (keep <= prev_s);
endmodule

// File: rtl/xcount_shaper.sv
module xcount_shaper
  import xts_pkg::*;
#(
  parameter int N_ELEM = 16,
  parameter int LEVEL_W = $clog2(N_ELEM + 1),
  parameter int CNT_W = LEVEL_W + 2,
  parameter int INT_W = 6,
  parameter bit HAS_ORDER2 = 1'b1,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst,
  input  logic order2,
  input  logic [LEVEL_W-1:0] avg_count,
  input  logic in_valid,
  output logic in_ready,
  input  logic [LEVEL_W-1:0] cur_level,
  input  logic [LEVEL_W-1:0] prev_level,
  output logic out_valid,
  input  logic out_ready,
  output logic signed [CNT_W-1:0] out_total,
  output logic signed [CNT_W-1:0] out_up,
  output logic out_ok
);
  logic take, odd, dith, ok_c;
  ofs_t ofs;
  logic signed [CNT_W-1:0] total_c, up_c;

  assign in_ready = !out_valid || out_ready;
  assign take = in_valid && in_ready;

  xts_dither_lfsr #(.LFSR_W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_dith (
    .clk(clk), .rst(rst), .step(take), .dith(dith));

  xts_shaping_loop #(.INT_W(INT_W), .HAS_ORDER2(HAS_ORDER2)) u_loop (
    .clk(clk), .rst(rst), .step(take), .odd(odd), .order2(order2),
    .dith(dith), .decision(ofs));

  xts_count_split #(.N_ELEM(N_ELEM), .LEVEL_W(LEVEL_W), .CNT_W(CNT_W)) u_split (
    .cur_level(cur_level), .prev_level(prev_level), .avg_count(avg_count),
    .loop_ofs(ofs), .odd(odd), .total(total_c), .up(up_c), .ok(ok_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_total <= '0;
      out_up    <= '0;
      out_ok    <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_total <= total_c;
      out_up    <= up_c;
      out_ok    <= ok_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xts_checker.sv
module xts_checker #(
  parameter int LEVEL_W = 5,
  parameter int CNT_W = 7
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic [LEVEL_W-1:0] avg_count,
  input logic [LEVEL_W-1:0] cur_level,
  input logic [LEVEL_W-1:0] prev_level,
  input logic out_valid,
  input logic out_ready,
  input logic signed [CNT_W-1:0] out_total,
  input logic signed [CNT_W-1:0] out_up
);
  logic signed [CNT_W-1:0] avg_e, chg_e;
  logic acc;
  assign avg_e = $signed({2'b00, avg_count});
  assign chg_e = $signed({2'b00, cur_level}) - $signed({2'b00, prev_level});
  assign acc = in_valid && in_ready;

  AST_PARITY_FOLLOWS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_total[0] == $past(chg_e[0])); // R1
  AST_TOTAL_NEAR_MEAN: assert property (@(posedge clk) disable iff (rst)
    acc |=> (out_total == $past(avg_e)) || (out_total == $past(avg_e) + 1) ||
            (out_total == $past(avg_e) - 1)); // R3
  AST_MEAN_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (acc && (chg_e[0] == avg_count[0])) |=> out_total == $past(avg_e)); // R2
  AST_UP_SPLIT: assert property (@(posedge clk) disable iff (rst)
    acc |=> (out_up <<< 1) == out_total + $past(chg_e)); // R5
  AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_total) && $stable(out_up)); // R8
endmodule

bind xcount_shaper xts_checker #(.LEVEL_W(LEVEL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .avg_count(avg_count), .cur_level(cur_level), .prev_level(prev_level),
  .out_valid(out_valid), .out_ready(out_ready), .out_total(out_total),
  .out_up(out_up));

// File: tb/tb_xcount_shaper.sv
`timescale 1ns/1ps
module tb_xcount_shaper;
  localparam int N = 16;
  localparam int LW = 5;
  localparam int CW = 7;

  logic clk = 0, rst = 1, order2 = 0, in_valid = 0, out_ready = 0;
  logic [LW-1:0] avg_count = 0, cur_level = 0, prev_level = 0;
  logic in_ready, out_valid, out_ok;
  logic signed [CW-1:0] out_total, out_up;

  int checks = 0, fails = 0;
  bit done = 0;

  int ms1, ms2;
  logic [15:0] mlfsr;
  bit e_valid, e_ok, e_odd, e_m2;
  int e_total, e_up, e_chg;

  always #2.5 clk = ~clk;

  xcount_shaper dut (.clk(clk), .rst(rst), .order2(order2), .avg_count(avg_count),
    .in_valid(in_valid), .in_ready(in_ready), .cur_level(cur_level),
    .prev_level(prev_level), .out_valid(out_valid), .out_ready(out_ready),
    .out_total(out_total), .out_up(out_up), .out_ok(out_ok));

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat6(input int v);
    if (v > 31) return 31;
    if (v < -32) return -32;
    return v;
  endfunction

  // Reference model of one accepted sample (R1..R7)
  task automatic model(input int c, input int p, input int a, input bit m2);
    int chg, q, y, tot, up, keep;
    bit odd;
    chg = c - p;
    odd = (chg & 1) != (a & 1);
    y = 0;
    if (odd) begin
      q = m2 ? ms2 + 2 * ms1 : ms1;
      y = (q < 0 || (q == 0 && mlfsr[0])) ? 1 : -1;
      ms1 = sat6(ms1 + y);
      if (m2) ms2 = sat6(ms2 + ms1);
    end
    mlfsr = {mlfsr[14:0], mlfsr[15] ^ mlfsr[13] ^ mlfsr[12] ^ mlfsr[10]};
    tot = a + y;
    up = (tot + chg) / 2;
    keep = c - up;
    e_total = tot; e_up = up; e_chg = chg; e_odd = odd; e_m2 = m2;
    e_ok = (tot >= 0) && (up >= 0) && (up <= N - p) && (keep >= 0) && (keep <= p);
  endtask

  task automatic cycle(input bit v, input int c, input int p, input int a,
                       input bit m2, input bit rdy);
    bit acc;
    @(negedge clk);
    chk(out_valid == e_valid, "R8 out_valid", out_valid, e_valid);
    if (e_valid && out_valid) begin
      chk(out_total[0] == e_chg[0], "R1 parity", out_total, e_chg);
      chk(out_total == e_total, e_m2 ? "R7 total" : (e_odd ? "R3 total" : "R2 total"),
          out_total, e_total);
      chk(out_up == e_up, "R5 up", out_up, e_up);
      chk(out_ok == e_ok, "R6 ok", out_ok, e_ok);
    end
    in_valid = v; cur_level = LW'(c); prev_level = LW'(p); avg_count = LW'(a);
    order2 = m2; out_ready = rdy;
    #0.5;
    chk(in_ready == (!e_valid || rdy), "R8 in_ready", in_ready, !e_valid || rdy);
    acc = v && (!e_valid || rdy);
    if (acc) begin
      model(c, p, a, m2);
      e_valid = 1;
    end else if (rdy) e_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    ms1 = 0; ms2 = 0; mlfsr = 16'hACE1; e_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0, "R9 out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R9 in_ready after reset", in_ready, 1);
    // R4: first odd sample after reset resolves tie with seed bit 0 = 1 -> avg+1
    cycle(1, 4, 3, 4, 0, 1);
    cycle(0, 0, 0, 0, 0, 1);
    chk(out_total == 5, "R4 dither tie", out_total, 5);
    // R2: matching parity keeps mean
    cycle(1, 5, 3, 4, 0, 1);
    cycle(1, 16, 16, 4, 0, 1);   // R6: no off elements, up=2 -> not ok
    cycle(1, 0, 0, 0, 0, 1);
    chk(out_ok == 0, "R6 no room", out_ok, 0);
    cycle(1, 1, 0, 0, 0, 0);     // R3: odd with avg 0, may go negative
    cycle(0, 0, 0, 0, 0, 0);     // R8: stall holds
    cycle(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 3000; i++) begin
      int p, c, a;
      bit m;
      p = $urandom_range(0, N);
      c = $urandom_range(0, N);
      a = ($urandom_range(0, 3) == 0) ? $urandom_range(0, N) : $urandom_range(2, 8);
      m = (i < 1000) ? 0 : ((i < 2000) ? 1 : ($urandom_range(0, 1) == 1));
      cycle($urandom_range(0, 4) != 0, c, p, a, m, $urandom_range(0, 3) != 0);
    end
    cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 0, 1);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule